// File: doc/BRIEF.md
# Serial Bus Address Arbiter

This block wins access to a shared, frame-based serial control bus on behalf of one local requester. Several controllers share a single open-drain, wired-AND line: a driven 0 overrides a released 1. A request comes from a hardware request-to-send line, which stays high until the requester's whole transfer is done, or from a software request. The block waits for a frame whose bus-free flag reads 1. In that same frame it shifts its own address onto the line, one bit per bit slot, and samples the line after each bit. If the line shows a 0 where the block sent a 1, a lower address has overridden it. The block then releases the line for the rest of its address and waits for a later free frame. A lower address therefore always wins, and an idle bus reads as the all-ones address.

After a win, the block drives the bus-free flag to 0 (busy) in every frame for as long as the request is held. It raises clear-to-send when the downstream stop/go bit reads 0, and it checks that bit again at each frame boundary. When the request drops, the block releases the bus at the next frame boundary and moves to a lower priority class. It may not arbitrate again until it has seen a set number of consecutive bus-free frames. Frame boundaries, bit-slot strobes and the sampled line, flag and stop/go values are all inputs. The request/clear-to-send pair is a level handshake, not a data stream, so there is no back-pressure at the edge of the block.

Top module: `serial_addr_arbiter`

## Requirements
- R1: After reset, `cts` and `granted` are 0, and `line_out` and `bac_out` are 1 (released).
- R2: The request is `rts` OR `sw_req`. Either one alone starts arbitration. With both low, the block never drives the line to 0.
- R3: Arbitration starts only at a `frame_start` pulse at which `bac_in` is 1 (1 = bus free). If `bac_in` is 0, the block keeps waiting and drives nothing in that frame.
- R4: In the frame in which arbitration starts, the address goes out MSB first. Each bit is held on `line_out` until the next `bit_slot` strobe, where `line_in` is sampled.
- R5: If a sampled `line_in` differs from the bit just sent, every remaining address bit of that frame is driven as 1. The block then waits, and it retries at the next free frame.
- R6: When all address bits are confirmed, `granted` goes to 1 and `bac_out` is held at 0 in every frame while the request stays high.
- R7: After a win, `cts` equals NOT `sg_in` as sampled when the last bit is confirmed. `cts` is updated from `sg_in` again at each `frame_start` while the block is granted. A stop/go value of 1 keeps ownership but holds `cts` at 0.
- R8: If the request is low at a `frame_start` while the block is granted, `cts` and `granted` fall to 0 and `bac_out` returns to 1.
- R9: After such a release, the block does not arbitrate until it has seen FREE_FRAMES consecutive frames with `bac_in` = 1. A busy frame restarts the count. Arbitration may start at the next free frame after that.
- R10: A block whose address is all ones wins when no other controller drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | ADDR_W | This controller's bus address |
| rts | input | 1 | Hardware request-to-send |
| sw_req | input | 1 | Software request for the control channel |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| bit_slot | input | 1 | One-cycle strobe at the end of each address bit slot |
| bac_in | input | 1 | Sampled bus-free flag (1 = free) |
| line_in | input | 1 | Sampled wired-AND address line |
| sg_in | input | 1 | Sampled downstream stop/go bit (0 = go) |
| line_out | output | 1 | Open-drain drive for the address line (1 = release) |
| bac_out | output | 1 | Open-drain drive for the bus-free flag (0 = busy) |
| cts | output | 1 | Clear-to-send to the local requester |
| granted | output | 1 | Bus currently owned by this controller |

## Verification
The bench builds the block with ADDR_W = 3 and FREE_FRAMES = 2. With these values, every address pattern it uses can be read bit by bit from the line, including the case of address 100 losing against 011, where a forced-1 tail differs from the block's own bits. Two recovery frames are few enough to interleave a busy frame and confirm that the count restarts. The other controllers on the line are modelled by ANDing the block's drive with a per-slot pattern chosen by the bench.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_OWN  = 2'd2
  } sba_state_t;
endpackage

// File: rtl/sba_addr_sender.sv
module sba_addr_sender #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              slot,
  input  logic              line_in,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              line_drv,
  output logic              busy,
  output logic              done,
  output logic              won
);
  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic [IDX_W-1:0] idx;
  logic             lost;
  logic             cur_bit;
  logic             miss;

  assign cur_bit  = my_addr[idx];
  assign miss     = slot && busy && !lost && (line_in != cur_bit);
  // once overridden, the rest of the address is released to 1
  assign line_drv = (busy && !lost) ? cur_bit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      lost <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      won  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        idx  <= IDX_W'(ADDR_W - 1);
        lost <= 1'b0;
      end else if (busy && slot) begin
        if (miss) lost <= 1'b1;
        if (idx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          won  <= !(lost || miss);
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  // R5
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(lost)) |-> line_drv);

  // R6
  won_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && won) |-> !$past(lost));
endmodule

// File: rtl/sba_recovery.sv
module sba_recovery #(
  parameter int FREE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic frame_start,
  input  logic bac_in,
  output logic ready
);
  localparam int CNT_W = (FREE_FRAMES > 1) ? $clog2(FREE_FRAMES + 1) : 1;

  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign ready = !armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && frame_start) begin
      if (!bac_in) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FREE_FRAMES - 1)) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9
  recov_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(frame_start) && $past(bac_in)));
endmodule

// File: rtl/serial_addr_arbiter.sv
module serial_addr_arbiter
  import sba_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int FREE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic              rts,
  input  logic              sw_req,
  input  logic              frame_start,
  input  logic              bit_slot,
  input  logic              bac_in,
  input  logic              line_in,
  input  logic              sg_in,
  output logic              line_out,
  output logic              bac_out,
  output logic              cts,
  output logic              granted
);
  sba_state_t st;
  logic req, start_arb, abort_arb, arm_recov;
  logic recov_ready, snd_busy, snd_done, snd_won, snd_line;

  assign req       = rts || sw_req;
  assign start_arb = (st == ST_IDLE) && frame_start && req && bac_in && recov_ready;
  assign abort_arb = (st == ST_ARB) && !req;
  assign arm_recov = (st == ST_OWN) && frame_start && !req;

  sba_addr_sender #(.ADDR_W(ADDR_W)) u_send (
    .clk(clk), .rst_n(rst_n), .start(start_arb), .abort(abort_arb),
    .slot(bit_slot), .line_in(line_in), .my_addr(my_addr),
    .line_drv(snd_line), .busy(snd_busy), .done(snd_done), .won(snd_won)
  );

  sba_recovery #(.FREE_FRAMES(FREE_FRAMES)) u_recov (
    .clk(clk), .rst_n(rst_n), .arm(arm_recov), .frame_start(frame_start),
    .bac_in(bac_in), .ready(recov_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cts <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_arb) st <= ST_ARB;
        ST_ARB: begin
          if (!req) begin
            st <= ST_IDLE;
          end else if (snd_done) begin
            st  <= snd_won ? ST_OWN : ST_IDLE;
            cts <= snd_won && !sg_in;
          end
        end
        ST_OWN: begin
          if (frame_start) begin
            if (!req) begin
              st  <= ST_IDLE;
              cts <= 1'b0;
            end else begin
              cts <= !sg_in;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign line_out = snd_line;
  assign bac_out  = (st != ST_OWN);
  assign granted  = (st == ST_OWN);

  // R7
  cts_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts |-> (st == ST_OWN));

  // R8
  release_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_OWN) |-> ($past(frame_start) && !$past(req)));

  // R3
  arb_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARB && $past(st) == ST_IDLE) |-> ($past(bac_in) && $past(recov_ready)));

  // R2
  idle_line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !snd_busy) |-> line_out);
endmodule

// File: tb/sim_serial_addr_arbiter.sv
`timescale 1ns/1ps
module sim_serial_addr_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] my_addr = 3'd0;
  logic       rts = 1'b0, sw_req = 1'b0, frame_start = 1'b0, bit_slot = 1'b0;
  logic       bac_in = 1'b1, sg_in = 1'b0, other_bit = 1'b1;
  logic       line_in, line_out, bac_out, cts, granted;
  int         tests = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign line_in = line_out & other_bit;

  serial_addr_arbiter #(.ADDR_W(3), .FREE_FRAMES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .rts(rts), .sw_req(sw_req),
    .frame_start(frame_start), .bit_slot(bit_slot), .bac_in(bac_in),
    .line_in(line_in), .sg_in(sg_in), .line_out(line_out), .bac_out(bac_out),
    .cts(cts), .granted(granted)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rts = 0; sw_req = 0; frame_start = 0; bit_slot = 0;
    bac_in = 1; sg_in = 0; other_bit = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // one frame: boundary pulse, three address slots, settle cycles
  task automatic run_frame(input logic bac, input logic [2:0] other,
                           input logic sg, output logic [2:0] seen);
    bac_in = bac; sg_in = sg;
    frame_start = 1; @(negedge clk); frame_start = 0;
    for (int i = 2; i >= 0; i--) begin
      other_bit = other[i];
      @(negedge clk);
      seen[i] = line_out;
      bit_slot = 1; @(negedge clk); bit_slot = 0;
    end
    other_bit = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 cts", cts, 0);
    check("R1 granted", granted, 0);
    check("R1 line_out", line_out, 1);
    check("R1 bac_out", bac_out, 1);
  endtask

  task automatic t_no_request();
    logic [2:0] s;
    do_reset(); my_addr = 3'b000;
    run_frame(1, 3'b111, 0, s);
    check("R2 line idle without request", s, 3'b111);
    check("R2 granted", granted, 0);
  endtask

  task automatic t_wait_then_win();
    logic [2:0] s;
    do_reset(); my_addr = 3'b101; rts = 1;
    run_frame(0, 3'b111, 0, s);
    check("R3 busy frame no drive", s, 3'b111);
    check("R3 granted", granted, 0);
    run_frame(1, 3'b111, 0, s);
    check("R4 msb-first pattern", s, 3'b101);
    check("R6 granted", granted, 1);
    check("R6 bac_out busy", bac_out, 0);
    check("R7 cts on win", cts, 1);
    run_frame(0, 3'b111, 1, s);
    check("R7 stop holds cts", cts, 0);
    check("R7 ownership kept", granted, 1);
    check("R6 bac_out still busy", bac_out, 0);
    run_frame(0, 3'b111, 0, s);
    check("R7 go restores cts", cts, 1);
    rts = 0;
    run_frame(0, 3'b111, 0, s);
    check("R8 cts dropped", cts, 0);
    check("R8 granted dropped", granted, 0);
    check("R8 bac_out released", bac_out, 1);
    rts = 1;
    run_frame(1, 3'b111, 0, s);
    check("R9 free frame 1 no arb", s, 3'b111);
    run_frame(0, 3'b111, 0, s);
    check("R9 busy frame no arb", s, 3'b111);
    run_frame(1, 3'b111, 0, s);
    check("R9 count restarted no arb", s, 3'b111);
    run_frame(1, 3'b111, 0, s);
    check("R9 second free no arb", s, 3'b111);
    check("R9 not granted yet", granted, 0);
    run_frame(1, 3'b111, 0, s);
    check("R9 arbitrates after recovery", s, 3'b101);
    check("R9 granted after recovery", granted, 1);
  endtask

  task automatic t_loss();
    logic [2:0] s;
    do_reset(); my_addr = 3'b100; sw_req = 1;
    run_frame(1, 3'b011, 0, s);
    check("R5 tail forced to ones", s, 3'b111);
    check("R5 lost not granted", granted, 0);
    check("R5 cts low", cts, 0);
    run_frame(1, 3'b111, 0, s);
    check("R5 retry pattern", s, 3'b100);
    check("R2 sw_req wins", granted, 1);
  endtask

  task automatic t_stop_at_win();
    logic [2:0] s;
    do_reset(); my_addr = 3'b111; rts = 1;
    run_frame(1, 3'b111, 1, s);
    check("R10 all-ones wins", granted, 1);
    check("R7 stop at win cts", cts, 0);
    run_frame(0, 3'b111, 0, s);
    check("R7 cts after go", cts, 1);
  endtask

  initial begin
    t_reset();
    t_no_request();
    t_wait_then_win();
    t_loss();
    t_stop_at_win();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule